// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is a software-managed local scratchpad that serves a whole batch of lane accesses at once. The storage is split into 32 independent single-port banks, each 32 bits wide. A batch carries up to 32 lane accesses. Each lane has an active bit, a read or write select, a word address and write data. A batch is presented with a valid strobe and is taken whenever the block is idle.

The bank of an access is taken from the low bits of its word address. Words at consecutive addresses therefore land in different banks, and a unit-stride batch finishes in one service cycle. When several active lanes name the same bank, the block replays them over extra cycles. Each cycle it serves one access per bank, picking the lowest pending lane of that bank. While it works through a batch, `busy_o` is high and new batches are refused. When the last access has been served, `done_o` pulses for one cycle and the per-lane read results are on `rd_data_o`.

The default capacity is 2^11 words (8 kB), which keeps elaboration small. Setting `ADDR_W` to 14 gives the full 64 kB (16384 words).

Top module: `lds_scratch`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and every lane of `rd_data_o` reads zero.
- R2: An access goes to bank `addr % 32`, which is address bits [4:0], at row `addr / 32`, which is the upper address bits. Each bank serves at most one access per cycle.
- R3: A batch whose active lanes all map to distinct banks keeps `busy_o` high for exactly one cycle after the accepting edge.
- R4: For a batch with at least one active lane, `busy_o` stays high for exactly as many cycles as the largest number of active lanes that map to a single bank.
- R5: Within one bank, accesses are served in order of increasing lane index, one per cycle. A read therefore returns any value written to the same address by a lower lane of the same batch. When two lanes of a batch write the same address, the higher lane's value remains.
- R6: A batch offered while `busy_o` is high is ignored. It writes nothing and does not extend the current batch.
- R7: `done_o` is high for the single cycle after `busy_o` falls. From then on, each read lane's `rd_data_o` field holds its result until a later batch reads on that lane.
- R8: Data written by one batch is returned by reads in any later batch, at every address of the capacity.
- R9: Inactive lanes neither write nor count toward the service time. A batch with no active lanes leaves `busy_o` low and raises `done_o` in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Batch present; taken on a clock edge when `busy_o` is low |
| req_act_i | input | LANES | Per-lane active bit |
| req_we_i | input | LANES | Per-lane write select (1 = write, 0 = read) |
| req_addr_i | input | LANES*ADDR_W | Per-lane word address; lane n at bits [n*ADDR_W +: ADDR_W] |
| req_wdata_i | input | LANES*DATA_W | Per-lane write data; lane n at bits [n*DATA_W +: DATA_W] |
| busy_o | output | 1 | Accesses of the current batch still pending |
| done_o | output | 1 | One-cycle pulse when a batch has been fully served |
| rd_data_o | output | LANES*DATA_W | Per-lane read result; lane n at bits [n*DATA_W +: DATA_W] |

## Verification
The hardest case to reach from the ports is a deep replay that mixes reads and writes. Here the order of service within a bank decides what a read returns, and a second batch knocks on the input while the first is still being replayed. The bench reaches it by sweeping address strides from 1 to 40 and conflict depths from 1 to 32. It also places writes and reads to one address on interleaved lanes of a single batch. During a 32-deep replay it holds a hostile write batch on the inputs and later reads those addresses back. Pseudo-random batches with random active and write masks fill the gaps. Each batch's expected service time is the largest per-bank count, and its expected read data comes from a word model applied in lane order.

// File: rtl/lds_scratch_pkg.sv
package lds_scratch_pkg;
  localparam int LANES_DEF  = 32;
  localparam int BANKS_DEF  = 32;
  localparam int DATA_W_DEF = 32;
  localparam int ADDR_W_DEF = 11;
endpackage

// File: rtl/lds_bank_pick.sv
// Lowest-index pending lane of one bank
module lds_bank_pick #(
  parameter int LANES  = 32,
  parameter int LIDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  req_i,
  output logic [LANES-1:0]  grant_o,
  output logic [LIDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (req_i[l]) idx_o = LIDX_W'(l);
    end
  end

  assign grant_o = req_i & (~req_i + 1'b1);
endmodule

// File: rtl/lds_bank_ram.sv
// Single-port bank: one read or one write per cycle
module lds_bank_ram #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[row_i] <= wdata_i;
  end

  assign rdata_o = mem[row_i];
endmodule

// File: rtl/lds_scratch.sv
module lds_scratch
  import lds_scratch_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int BANKS  = BANKS_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [LANES-1:0]        req_act_i,
  input  logic [LANES-1:0]        req_we_i,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES*DATA_W-1:0] req_wdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [LANES*DATA_W-1:0] rd_data_o
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int LIDX_W = $clog2(LANES);

  logic [LANES-1:0]              pend_q, we_q, lane_gnt;
  logic [LANES-1:0][ADDR_W-1:0]  addr_q;
  logic [LANES-1:0][DATA_W-1:0]  wd_q, rd_q;
  logic                          done_q, accept;

  logic [BANKS-1:0][LANES-1:0]   bank_req, bank_gnt;
  logic [BANKS-1:0][LIDX_W-1:0]  bank_idx;
  logic [BANKS-1:0][DATA_W-1:0]  bank_rd;

  assign busy_o = |pend_q;
  assign accept = req_valid_i && !busy_o;
  assign done_o = done_q;

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        bank_req[b][l] = pend_q[l] && (addr_q[l][BANK_W-1:0] == BANK_W'(b));
      end
    end
  end

  always_comb begin
    lane_gnt = '0;
    for (int b = 0; b < BANKS; b++) lane_gnt |= bank_gnt[b];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              b_en;
    logic [ROW_W-1:0]  b_row;

    lds_bank_pick #(.LANES(LANES), .LIDX_W(LIDX_W)) u_pick (
      .req_i   (bank_req[b]),
      .grant_o (bank_gnt[b]),
      .idx_o   (bank_idx[b])
    );

    assign b_en  = |bank_gnt[b];
    assign b_row = addr_q[bank_idx[b]][ADDR_W-1:BANK_W];

    lds_bank_ram #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_ram (
      .clk_i   (clk_i),
      .we_i    (b_en && we_q[bank_idx[b]]),
      .row_i   (b_row),
      .wdata_i (wd_q[bank_idx[b]]),
      .rdata_o (bank_rd[b])
    );

    // R2: one access per bank per cycle
    p_one_per_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bank_gnt[b]));
    // R5: grant is the lowest pending lane of the bank
    p_lowest_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((bank_gnt[b] & ~bank_req[b]) == '0) &&
      (((bank_gnt[b] - 1'b1) & bank_req[b]) == '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      we_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (accept && (req_act_i == '0)) ||
                (busy_o && ((pend_q & ~lane_gnt) == '0));
      if (accept) begin
        pend_q <= req_act_i;
        we_q   <= req_we_i;
        for (int l = 0; l < LANES; l++) begin
          addr_q[l] <= req_addr_i[l*ADDR_W +: ADDR_W];
          wd_q[l]   <= req_wdata_i[l*DATA_W +: DATA_W];
        end
      end else begin
        pend_q <= pend_q & ~lane_gnt;
      end
      for (int l = 0; l < LANES; l++) begin
        if (lane_gnt[l] && !we_q[l]) rd_q[l] <= bank_rd[addr_q[l][BANK_W-1:0]];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) rd_data_o[l*DATA_W +: DATA_W] = rd_q[l];
  end

  // R6: no new pending lanes appear while busy
  p_hold_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ((pend_q & ~$past(pend_q)) == '0));
  // R4: every busy cycle retires at least one access
  p_progress_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($countones(pend_q) < $countones($past(pend_q))));
  // R7: completion follows the end of service
  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/sim_lds_scratch.sv
`timescale 1ns/1ps
module sim_lds_scratch;
  localparam int LANES = 32, BANKS = 32, DW = 32, AW = 11;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LANES-1:0] req_act = '0, req_we = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [LANES*DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  lds_scratch #(.LANES(LANES), .BANKS(BANKS), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_act_i(req_act),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .rd_data_o(rd_data));

  int errors = 0, checks = 0;
  logic [DW-1:0] model [WORDS];
  logic [LANES-1:0] b_act, b_we;
  logic [AW-1:0] b_addr [LANES];
  logic [DW-1:0] b_wd [LANES];
  logic [DW-1:0] exp_rd [LANES];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  // Runs the current batch (b_*); junk=1 offers a write batch while busy
  task automatic run_batch(input string tag, input bit junk);
    int cnt [BANKS];
    int exp_cyc, cyc;
    for (int b = 0; b < BANKS; b++) cnt[b] = 0;
    exp_cyc = 0;
    for (int l = 0; l < LANES; l++) begin
      if (b_act[l]) begin
        cnt[b_addr[l] % BANKS]++;
        if (cnt[b_addr[l] % BANKS] > exp_cyc) exp_cyc = cnt[b_addr[l] % BANKS];
        if (b_we[l]) model[b_addr[l]] = b_wd[l];
        else exp_rd[l] = model[b_addr[l]];
      end
    end
    req_valid = 1'b1; req_act = b_act; req_we = b_we;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW] = b_addr[l];
      req_wdata[l*DW +: DW] = b_wd[l];
    end
    @(posedge clk); @(negedge clk);
    if (junk) begin
      req_act = '1; req_we = '1;
      for (int l = 0; l < LANES; l++) req_wdata[l*DW +: DW] = ~b_wd[l] ^ 32'h5A5A_0F0F;
    end else req_valid = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++; @(negedge clk);
    end
    req_valid = 1'b0;
    chk(tag, "busy cycles", 64'(cyc), 64'(exp_cyc));
    chk(tag, "done pulse", 64'(done), 64'd1);
    for (int l = 0; l < LANES; l++) begin
      if (b_act[l] && !b_we[l])
        chk(tag, $sformatf("rd lane %0d", l), 64'(rd_data[l*DW +: DW]), 64'(exp_rd[l]));
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int l = 0; l < LANES; l++) exp_rd[l] = '0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "rd_data upper", 64'(rd_data[LANES*DW-1 -: 64]), 64'd0);
    chk("R1", "rd_data lower", 64'(rd_data[63:0]), 64'd0);

    // R2 R3 R8: fill every word with unit-stride writes
    for (int k = 0; k < WORDS / LANES; k++) begin
      b_act = '1; b_we = '1;
      for (int l = 0; l < LANES; l++) begin
        b_addr[l] = AW'(k * LANES + l);
        b_wd[l] = (32'(k * LANES + l) * 32'h9E37_79B1) ^ 32'hC0DE_0000;
      end
      run_batch("R3_fill", 1'b0);
    end
    for (int k = 0; k < WORDS / LANES; k++) begin
      b_act = '1; b_we = '0;
      for (int l = 0; l < LANES; l++) b_addr[l] = AW'(k * LANES + (l ^ 5));
      run_batch("R8_readback", 1'b0);
    end

    // R2 R4: stride sweep with mixed writes
    for (int s = 1; s <= 40; s++) begin
      b_act = '1;
      for (int l = 0; l < LANES; l++) begin
        b_we[l] = ((l + s) % 3 == 0);
        b_addr[l] = AW'((s * 7 + l * s) % WORDS);
        b_wd[l] = 32'(s * 1000 + l);
      end
      run_batch("R4_stride", 1'b0);
    end

    // R4: conflict depth 1..32, write then read
    for (int d = 1; d <= 32; d = d * 2) begin
      for (int pass = 0; pass < 2; pass++) begin
        b_act = '1; b_we = pass == 0 ? '1 : '0;
        for (int l = 0; l < LANES; l++) begin
          b_addr[l] = AW'((l % (LANES / d)) + BANKS * (l / (LANES / d)) + 3 * d);
          b_wd[l] = 32'hA000_0000 | 32'(d * 64 + l);
        end
        run_batch("R4_depth", 1'b0);
      end
    end

    // R4 R5 R9: pseudo-random batches
    for (int n = 0; n < 200; n++) begin
      seed = xs(seed); b_act = seed;
      seed = xs(seed); b_we = seed;
      for (int l = 0; l < LANES; l++) begin
        seed = xs(seed);
        b_addr[l] = (n % 4 == 0) ? AW'(seed[6:0]) : AW'(seed);
        b_wd[l] = xs(seed ^ 32'h0BAD_F00D);
      end
      run_batch("R4_R9_random", 1'b0);
    end

    // R5: in-batch ordering at one address in bank 5
    b_act = '0; b_we = '0;
    for (int l = 0; l < LANES; l++) begin b_addr[l] = '0; b_wd[l] = '0; end
    b_act[4:0] = '1;
    b_we[0] = 1; b_addr[0] = 5;  b_wd[0] = 32'h1111_1111;
    b_we[1] = 0; b_addr[1] = 5;
    b_we[2] = 1; b_addr[2] = 5;  b_wd[2] = 32'h2222_2222;
    b_we[3] = 0; b_addr[3] = 5;
    b_we[4] = 0; b_addr[4] = 37;
    run_batch("R5_order", 1'b0);
    chk("R5", "lane1 sees lane0 write", 64'(rd_data[1*DW +: DW]), 64'h1111_1111);
    chk("R5", "lane3 sees lane2 write", 64'(rd_data[3*DW +: DW]), 64'h2222_2222);
    // R7: results held, done single cycle
    @(negedge clk);
    chk("R7", "done low after pulse", 64'(done), 64'd0);
    chk("R7", "lane3 held", 64'(rd_data[3*DW +: DW]), 64'h2222_2222);
    // R5: two writes, higher lane wins
    b_act = '0; b_act[1:0] = '1; b_we = '0; b_we[1:0] = 2'b11;
    b_addr[0] = 9; b_wd[0] = 32'h0000_AAAA; b_addr[1] = 9; b_wd[1] = 32'h0000_BBBB;
    run_batch("R5_ww", 1'b0);
    b_act = '0; b_act[7] = 1; b_we = '0; b_addr[7] = 9;
    run_batch("R5_ww_read", 1'b0);
    chk("R5", "higher lane write kept", 64'(rd_data[7*DW +: DW]), 64'h0000_BBBB);

    // R6: hostile batch offered during a 32-deep replay
    b_act = '1; b_we = '0;
    for (int l = 0; l < LANES; l++) begin b_addr[l] = AW'(l * BANKS + 17); b_wd[l] = 32'(l); end
    run_batch("R6_busy_offer", 1'b1);
    b_act = '1; b_we = '0;
    for (int l = 0; l < LANES; l++) b_addr[l] = AW'(((LANES - 1 - l) * BANKS + 17));
    run_batch("R6_untouched", 1'b0);

    // R9: empty batch with write bits set
    b_act = '0; b_we = '1;
    for (int l = 0; l < LANES; l++) begin b_addr[l] = AW'(l); b_wd[l] = 32'hDEAD_0000; end
    run_batch("R9_empty", 1'b0);
    b_act = '1; b_we = '0;
    run_batch("R9_no_write", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule